// File: doc/BRIEF.md
# Converter Channel Sequence Store

This block keeps an ordered list of conversion set-ups for a multichannel converter front end. Every list slot holds a 7-bit entry: a differential flag, a 3-bit input channel, a bipolar flag, a gain flag and a last-entry flag. A host selects a configuration mode with two mode inputs. In that mode each write strobe stores the present configuration inputs and moves to the next slot. Each read strobe shows the stored entry at the current slot and then moves to the next slot.

In run mode, the block offers the entry at the current slot to the conversion controller. Each conversion-start strobe moves the block to the next slot. The slot number returns to 0 after an entry whose last-entry flag is set, and also after the final slot. Out of reset, every slot holds a default entry with the last-entry flag set. An unprogrammed block therefore repeats slot 0 for every conversion. The busy output stays low for the whole time the block is in configuration mode.

All strobes are active low and are sampled on `clk`. The block acts on the edges of the strobes that it detects between one clock and the next.

Top module: `adc_seq_mem`

## Requirements
- R1: An entry is 7 bits wide. Bit 6 is the differential flag (1 = differential). Bits 5:3 are the channel. Bit 2 is the bipolar flag (1 = bipolar). Bit 1 is the gain flag (1 = gain 1, 0 = gain 2). Bit 0 is the last-entry flag. This layout applies on both `bus_data` and `next_entry`.
- R2: After reset, `busy_n` is 1, `loc_o` is 0, `bus_oe` is 0, and every slot holds 7'b0000011.
- R3: The cycle after `mode_m1`=1 and `mode_m0`=0 is sampled, `busy_n` is 0. It stays 0, even if `mode_m1` drops, until `mode_m0`=1 is sampled; the next cycle `busy_n` is 1.
- R4: `loc_o` becomes 0 on the clock that enters configuration mode and on the clock that leaves it.
- R5: In configuration mode, while `wr_n` is low, `bus_oe` is 1 and `bus_data` follows the configuration inputs combinationally.
- R6: In configuration mode, a rising `wr_n` stores the configuration inputs at `loc_o` and advances `loc_o` by one.
- R7: In configuration mode, while `rd_n` is low, `bus_data` shows the entry stored at `loc_o`. A rising `rd_n` advances `loc_o` by one.
- R8: In run mode, `next_entry` is the entry at `loc_o`. A falling `conv_n` advances `loc_o`, and `loc_o` returns to 0 when that entry's last-entry flag is set.
- R9: A step from slot DEPTH-1 (15) goes to slot 0, in run mode and in configuration mode alike.
- R10: In run mode, `wr_n` and `rd_n` have no effect. `bus_oe` stays 0, `bus_data` stays 0, nothing is stored and `loc_o` does not move.
- R11: With no programming, every conversion uses slot 0, and `next_entry` stays 7'b0000011.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_m1 | input | 1 | Mode select, high bit |
| mode_m0 | input | 1 | Mode select, low bit |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| conv_n | input | 1 | Conversion start, active on its falling edge |
| cfg_diff | input | 1 | Differential select |
| cfg_chan | input | 3 | Channel address |
| cfg_bip | input | 1 | Bipolar select |
| cfg_gain | input | 1 | Gain select (1 = gain 1) |
| cfg_eos | input | 1 | Last-entry flag |
| next_entry | output | 7 | Entry at the current slot, for the conversion controller |
| bus_data | output | 7 | Configuration-mode output bus |
| bus_oe | output | 1 | Output bus drive enable |
| busy_n | output | 1 | Low while in configuration mode |
| loc_o | output | 4 | Current slot number |

## Verification
The assertions assume that the mode pins and the strobes are synchronous to `clk` and hold each level for at least one clock. They also assume that a write or read strobe never rises on the same clock as a mode change. If a strobe edge came between two clocks and reversed before the next, the block would not see it. The bench drives every input on the falling clock edge and holds each level for at least one full cycle. It changes the mode only while both strobes are idle and high, and it lets at least one clock pass between a strobe edge and a mode change.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef struct packed {
    logic       diff;
    logic [2:0] chan;
    logic       bip;
    logic       gain;
    logic       eos;
  } seq_entry_t;

  localparam seq_entry_t ENTRY_DEFAULT = '{diff: 1'b0, chan: 3'd0, bip: 1'b0,
                                          gain: 1'b1, eos: 1'b1};

  function automatic seq_entry_t pack_cfg(input logic d, input logic [2:0] c,
                                          input logic b, input logic g,
                                          input logic e);
    seq_entry_t r;
    r.diff = d;
    r.chan = c;
    r.bip  = b;
    r.gain = g;
    r.eos  = e;
    return r;
  endfunction

endpackage

// File: rtl/adc_seq_mode.sv
module adc_seq_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_m1,
  input  logic mode_m0,
  input  logic wr_n,
  input  logic rd_n,
  input  logic conv_n,
  output logic prog_mode,
  output logic prog_enter,
  output logic prog_exit,
  output logic wr_rise,
  output logic rd_rise,
  output logic conv_fall
);
  logic prog_next;
  logic wr_q, rd_q, conv_q;

  // mode_m0 high always releases; mode_m1 high with mode_m0 low enters; else hold
  always_comb begin
    if (mode_m0)      prog_next = 1'b0;
    else if (mode_m1) prog_next = 1'b1;
    else              prog_next = prog_mode;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_mode <= 1'b0;
      wr_q      <= 1'b1;
      rd_q      <= 1'b1;
      conv_q    <= 1'b1;
    end else begin
      prog_mode <= prog_next;
      wr_q      <= wr_n;
      rd_q      <= rd_n;
      conv_q    <= conv_n;
    end
  end

  assign prog_enter = !prog_mode && prog_next;
  assign prog_exit  = prog_mode && !prog_next;
  assign wr_rise    = prog_mode && wr_n && !wr_q;
  assign rd_rise    = prog_mode && rd_n && !rd_q;
  assign conv_fall  = !prog_mode && !conv_n && conv_q;
endmodule

// File: rtl/adc_seq_loc.sv
module adc_seq_loc #(
  parameter int DEPTH = 16,
  localparam int LOC_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_enter,
  input  logic             prog_exit,
  input  logic             wr_rise,
  input  logic             rd_rise,
  input  logic             conv_fall,
  input  logic             cur_eos,
  output logic [LOC_W-1:0] loc
);
  localparam logic [LOC_W-1:0] LAST = LOC_W'(DEPTH - 1);

  function automatic logic [LOC_W-1:0] step(input logic [LOC_W-1:0] l);
    return (l == LAST) ? '0 : l + 1'b1;
  endfunction

  function automatic logic [LOC_W-1:0] run_step(input logic [LOC_W-1:0] l,
                                                input logic eos);
    return eos ? '0 : step(l);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      loc <= '0;
    else if (prog_enter || prog_exit) loc <= '0;
    else if (wr_rise || rd_rise)      loc <= step(loc);
    else if (conv_fall)               loc <= run_step(loc, cur_eos);
  end
endmodule

// File: rtl/adc_seq_store.sv
module adc_seq_store
  import adc_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LOC_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             store_en,
  input  logic [LOC_W-1:0] loc,
  input  seq_entry_t       wr_entry,
  output seq_entry_t       rd_entry
);
  seq_entry_t slots [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                slots[i] <= ENTRY_DEFAULT;
      else if (store_en && loc == LOC_W'(i))     slots[i] <= wr_entry;
    end
  end

  assign rd_entry = slots[loc];
endmodule

// File: rtl/adc_seq_mem.sv
module adc_seq_mem
  import adc_seq_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LOC_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_m1,
  input  logic             mode_m0,
  input  logic             wr_n,
  input  logic             rd_n,
  input  logic             conv_n,
  input  logic             cfg_diff,
  input  logic [2:0]       cfg_chan,
  input  logic             cfg_bip,
  input  logic             cfg_gain,
  input  logic             cfg_eos,
  output logic [6:0]       next_entry,
  output logic [6:0]       bus_data,
  output logic             bus_oe,
  output logic             busy_n,
  output logic [LOC_W-1:0] loc_o
);
  logic       prog_mode, prog_enter, prog_exit;
  logic       wr_rise, rd_rise, conv_fall;
  seq_entry_t cfg_word, stored;
  logic [LOC_W-1:0] loc;

  assign cfg_word = pack_cfg(cfg_diff, cfg_chan, cfg_bip, cfg_gain, cfg_eos);

  adc_seq_mode u_mode (
    .clk(clk), .rst_n(rst_n), .mode_m1(mode_m1), .mode_m0(mode_m0),
    .wr_n(wr_n), .rd_n(rd_n), .conv_n(conv_n),
    .prog_mode(prog_mode), .prog_enter(prog_enter), .prog_exit(prog_exit),
    .wr_rise(wr_rise), .rd_rise(rd_rise), .conv_fall(conv_fall)
  );

  adc_seq_loc #(.DEPTH(DEPTH)) u_loc (
    .clk(clk), .rst_n(rst_n), .prog_enter(prog_enter), .prog_exit(prog_exit),
    .wr_rise(wr_rise), .rd_rise(rd_rise), .conv_fall(conv_fall),
    .cur_eos(stored.eos), .loc(loc)
  );

  adc_seq_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .store_en(wr_rise), .loc(loc),
    .wr_entry(cfg_word), .rd_entry(stored)
  );

  // write phase has precedence over read phase on the shared bus
  always_comb begin
    bus_oe   = prog_mode && (!wr_n || !rd_n);
    bus_data = '0;
    if (prog_mode && !wr_n)      bus_data = cfg_word;
    else if (prog_mode && !rd_n) bus_data = stored;
  end

  assign next_entry = stored;
  assign busy_n     = !prog_mode;
  assign loc_o      = loc;
endmodule

// File: rtl/adc_seq_mem_chk.sv
module adc_seq_mem_chk #(
  parameter int DEPTH = 16,
  localparam int LOC_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_m1,
  input logic             mode_m0,
  input logic             busy_n,
  input logic [LOC_W-1:0] loc,
  input logic             wr_rise,
  input logic             rd_rise,
  input logic             conv_fall,
  input logic             cur_eos,
  input logic             bus_oe
);
  localparam logic [LOC_W-1:0] LAST = LOC_W'(DEPTH - 1);

  p_busy_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_m1 && !mode_m0) |=> !busy_n);

  p_busy_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_m0 |=> busy_n);

  p_loc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_n && mode_m1 && !mode_m0) |=> (loc == '0));

  p_write_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_rise && !mode_m0) |=>
      (loc == (($past(loc) == LAST) ? '0 : $past(loc) + 1'b1)));

  p_read_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rise && !mode_m0) |=>
      (loc == (($past(loc) == LAST) ? '0 : $past(loc) + 1'b1)));

  p_eos_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_fall && cur_eos) |=> (loc == '0));

  p_last_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_fall && loc == LAST) |=> (loc == '0));

  p_run_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_n |-> !bus_oe);
endmodule

bind adc_seq_mem adc_seq_mem_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_m1(mode_m1), .mode_m0(mode_m0),
  .busy_n(busy_n), .loc(loc), .wr_rise(wr_rise), .rd_rise(rd_rise),
  .conv_fall(conv_fall), .cur_eos(stored.eos), .bus_oe(bus_oe)
);

// File: tb/adc_seq_mem_test.sv
`timescale 1ns/1ps
module adc_seq_mem_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_m1 = 1'b0, mode_m0 = 1'b1;
  logic wr_n = 1'b1, rd_n = 1'b1, conv_n = 1'b1;
  logic cfg_diff = 1'b0, cfg_bip = 1'b0, cfg_gain = 1'b0, cfg_eos = 1'b0;
  logic [2:0] cfg_chan = 3'd0;
  logic [6:0] next_entry, bus_data;
  logic bus_oe, busy_n;
  logic [3:0] loc_o;

  int n_tests = 0, n_fail = 0;
  logic [6:0] exp_q [$];
  string tag_q [$];
  logic take_bus = 1'b0, take_run = 1'b0;

  always #2 clk = ~clk;

  adc_seq_mem uut (
    .clk(clk), .rst_n(rst_n), .mode_m1(mode_m1), .mode_m0(mode_m0),
    .wr_n(wr_n), .rd_n(rd_n), .conv_n(conv_n), .cfg_diff(cfg_diff),
    .cfg_chan(cfg_chan), .cfg_bip(cfg_bip), .cfg_gain(cfg_gain),
    .cfg_eos(cfg_eos), .next_entry(next_entry), .bus_data(bus_data),
    .bus_oe(bus_oe), .busy_n(busy_n), .loc_o(loc_o)
  );

  // R1 layout, restated from the requirement
  function automatic logic [6:0] enc(input logic d, input logic [2:0] c,
                                     input logic b, input logic g, input logic e);
    logic [6:0] w;
    w[6] = d; w[5:3] = c; w[2] = b; w[1] = g; w[0] = e;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input string tag, input logic [6:0] v);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // monitor: pops expected items when the driver marks a result
  always begin
    @(negedge clk); #1;
    if (take_bus || take_run) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 1, 0);
      else begin
        string t;
        logic [6:0] e;
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        chk(t, take_bus ? bus_data : next_entry, e);
      end
    end
  end

  task automatic set_mode(input logic m1, input logic m0);
    @(negedge clk); mode_m1 = m1; mode_m0 = m0;
    @(negedge clk); #1;
  endtask

  task automatic prog_write(input logic d, input logic [2:0] c, input logic b,
                            input logic g, input logic e, input string tag);
    @(negedge clk);
    cfg_diff = d; cfg_chan = c; cfg_bip = b; cfg_gain = g; cfg_eos = e;
    wr_n = 1'b0; take_bus = 1'b1; push(tag, enc(d, c, b, g, e));
    #1 chk("R5 bus_oe during write", bus_oe, 1);
    @(negedge clk); take_bus = 1'b0; wr_n = 1'b1;
    @(negedge clk); #1;
  endtask

  task automatic rb_read(input logic [6:0] v, input string tag);
    @(negedge clk); rd_n = 1'b0; take_bus = 1'b1; push(tag, v);
    @(negedge clk); take_bus = 1'b0; rd_n = 1'b1;
    @(negedge clk); #1;
  endtask

  task automatic convert(input logic [6:0] v, input string tag);
    @(negedge clk); conv_n = 1'b0; take_run = 1'b1; push(tag, v);
    @(negedge clk); take_run = 1'b0; conv_n = 1'b1;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  logic [6:0] e0, e1, e2;

  initial begin
    e0 = enc(1'b1, 3'd5, 1'b0, 1'b1, 1'b0);
    e1 = enc(1'b0, 3'd3, 1'b1, 1'b0, 1'b0);
    e2 = enc(1'b0, 3'd6, 1'b0, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R2 busy_n after reset", busy_n, 1);
    chk("R2 loc after reset", loc_o, 0);
    chk("R2 bus_oe after reset", bus_oe, 0);
    chk("R2 default entry", next_entry, 7'b0000011);

    // R11: unprogrammed run repeats slot 0
    for (int i = 0; i < 3; i++) convert(7'b0000011, "R11 default conversion");
    chk("R11 loc stays 0", loc_o, 0);

    // R10: write and read strobes ignored in run mode
    @(negedge clk);
    cfg_diff = 1'b1; cfg_chan = 3'd7; cfg_bip = 1'b1; cfg_gain = 1'b0; cfg_eos = 1'b0;
    wr_n = 1'b0; rd_n = 1'b0;
    #1 chk("R10 bus_oe in run", bus_oe, 0);
    chk("R10 bus_data in run", bus_data, 0);
    @(negedge clk); wr_n = 1'b1; rd_n = 1'b1;
    @(negedge clk); #1;
    chk("R10 loc unchanged", loc_o, 0);
    chk("R10 nothing stored", next_entry, 7'b0000011);

    // R3/R4: enter configuration mode
    set_mode(1'b1, 1'b0);
    chk("R3 busy_n low in config", busy_n, 0);
    chk("R4 loc cleared on entry", loc_o, 0);

    prog_write(1'b1, 3'd5, 1'b0, 1'b1, 1'b0, "R5 R1 write bus e0");
    chk("R6 loc after write 1", loc_o, 1);
    prog_write(1'b0, 3'd3, 1'b1, 1'b0, 1'b0, "R5 R1 write bus e1");
    chk("R6 loc after write 2", loc_o, 2);
    prog_write(1'b0, 3'd6, 1'b0, 1'b1, 1'b1, "R5 R1 write bus e2");
    chk("R6 loc after write 3", loc_o, 3);

    set_mode(1'b0, 1'b0);
    chk("R3 busy_n held with m1 low", busy_n, 0);
    set_mode(1'b0, 1'b1);
    chk("R3 busy_n released by m0", busy_n, 1);
    chk("R4 loc cleared on exit", loc_o, 0);

    // R7: readback
    set_mode(1'b1, 1'b0);
    chk("R4 loc cleared on re-entry", loc_o, 0);
    rb_read(e0, "R7 readback e0");
    chk("R7 loc after read", loc_o, 1);
    rb_read(e1, "R7 readback e1");
    rb_read(e2, "R7 readback e2");
    chk("R7 loc after three reads", loc_o, 3);
    rb_read(7'b0000011, "R7 readback untouched slot");

    // R8: run through a 3-entry sequence
    set_mode(1'b0, 1'b1);
    convert(e0, "R8 run e0");
    chk("R8 loc advance", loc_o, 1);
    convert(e1, "R8 run e1");
    convert(e2, "R8 run e2");
    chk("R8 wrap after last-entry flag", loc_o, 0);
    convert(e0, "R8 run e0 again");
    convert(e1, "R8 run e1 again");

    // R9: full 16-slot sequence without last-entry flag
    set_mode(1'b1, 1'b0);
    for (int i = 0; i < 16; i++) begin
      logic [3:0] k;
      k = 4'(i);
      prog_write(k[3], k[2:0], k[0], ~k[1], 1'b0, "R6 write full table");
    end
    chk("R9 loc wraps after slot 15 write", loc_o, 0);
    set_mode(1'b0, 1'b1);
    for (int i = 0; i < 16; i++) begin
      logic [3:0] k;
      k = 4'(i);
      convert(enc(k[3], k[2:0], k[0], ~k[1], 1'b0), "R9 run full table");
    end
    chk("R9 loc wraps after slot 15 run", loc_o, 0);
    convert(enc(1'b0, 3'd0, 1'b0, 1'b1, 1'b0), "R9 run slot 0 after wrap");

    repeat (2) @(negedge clk);
    chk("scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule